// File: doc/BRIEF.md
# Dual-Space I2C Register Target

This block is the serial front-end of a supervisory controller. It oversamples SCL and SDA with the system clock and detects Start and Stop conditions. It shifts bytes most significant bit first and acknowledges on the ninth clock by pulling SDA low through an open-drain enable. The address byte decides whether the transfer reaches the memory/configuration space or the command/status space. It also carries a three-bit bus address that must match the local strapping.

A write loads the byte that follows the address byte into a byte pointer. Each further data byte is then presented on a simple register bus as a one-cycle write strobe, and the pointer advances. A read returns the byte at the pointer, then bytes from the following addresses for as long as the controller acknowledges. The pointer survives a repeated Start, so a write without data followed by a repeated Start and a read selects where the read begins.

The block holds a monitor-halt flag for the whole addressed transaction. It issues a single commit pulse when a memory-space page write ends with a Stop; this pulse starts the nonvolatile write.

Top module: `i2c_dual_space_target`

## Requirements
- R1: After reset, sda_oe_o, mon_halt_o, commit_o, reg_we_o and reg_re_o are all 0.
- R2: The address byte is {type[3:0], bus_addr[2:0], rw}, with rw=1 meaning read. Type 1010 selects the memory space when cfg_alt_id_i=0. Type 1011 selects it when cfg_alt_id_i=1. The unselected one of these two codes is not acknowledged.
- R3: Type 1001 selects the command space, shown by reg_space_o=1. Reads and writes then reach that space only.
- R4: The expected bus address is {cfg_ba2_pin_i ? a2_i : 0, cfg_ba_i[1:0]}. An address byte whose bits 3:1 differ from it is not acknowledged.
- R5: mon_halt_o rises when an address byte is acknowledged. It stays high through a repeated Start and falls after a Stop.
- R6: In a write, the first byte after the address loads the pointer. Each following byte is acknowledged and written with one reg_we_o pulse at reg_addr_o = pointer, and the pointer then advances.
- R7: In the memory space, pointer advances during a write wrap within bits 3:0, so 0x5F is followed by 0x50. A 17th data byte in one write is not acknowledged and not written.
- R8: commit_o pulses for one cycle after a Stop that ends a memory-space write with at least one data byte. A command-space write, a write with no data, and a write ended by a repeated Start give no pulse.
- R9: A read first returns the byte at the pointer left by the previous write. The next byte comes from the next address after each controller acknowledge. A controller not-acknowledge ends the read with SDA released.
- R10: In the command space, writes advance the full 8-bit pointer (0xFF is followed by 0x00) with no 16-byte limit.
- R11: The target changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |
| cfg_alt_id_i | input | 1 | Selects 1011 instead of 1010 as the memory type code |
| cfg_ba_i | input | 2 | Expected bus address bits 1:0 |
| cfg_ba2_pin_i | input | 1 | 1: bus address bit 2 comes from a2_i; 0: it is 0 |
| a2_i | input | 1 | Strap pin for bus address bit 2 |
| reg_space_o | output | 1 | 0 memory/configuration space, 1 command/status space |
| reg_addr_o | output | AddrW | Current byte pointer |
| reg_wdata_o | output | 8 | Write data |
| reg_we_o | output | 1 | One-cycle write strobe |
| reg_re_o | output | 1 | One-cycle strobe when a read byte is taken |
| reg_rdata_i | input | 8 | Read data for reg_addr_o in reg_space_o, combinational |
| mon_halt_o | output | 1 | High while an addressed transaction is open |
| commit_o | output | 1 | One-cycle pulse that starts the nonvolatile write |

## Verification
A Stop at the end of a memory page write must drop the halt flag and launch the commit in the same clock edge. A repeated Start, by contrast, must clear the pending commit while leaving both the halt flag and the pointer untouched. The bench provokes both orderings: page writes closed by Stop, and a write followed by a repeated Start, a read and a Stop. It judges them by counting commit pulses against a running expected count, by checking the halt level after each bus event, and by checking the byte returned from the preserved pointer. A per-clock monitor also checks that commit pulses last one cycle and that the SDA drive never changes while SCL is high.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_PTR, ST_PTR_ACK,
    ST_WR, ST_WR_ACK, ST_RD, ST_RD_ACK
  } tgt_state_e;

  localparam logic [3:0] TYPE_MEM     = 4'b1010;
  localparam logic [3:0] TYPE_MEM_ALT = 4'b1011;
  localparam logic [3:0] TYPE_CMD     = 4'b1001;
endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int unsigned SyncStages = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int unsigned Depth = SyncStages + 1;

  logic [Depth-1:0] scl_pipe, sda_pipe;
  logic scl_prev, sda_prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
    end else begin
      scl_pipe <= {scl_pipe[Depth-2:0], scl_i};
      sda_pipe <= {sda_pipe[Depth-2:0], sda_i};
    end
  end

  assign scl_o    = scl_pipe[Depth-2];
  assign sda_o    = sda_pipe[Depth-2];
  assign scl_prev = scl_pipe[Depth-1];
  assign sda_prev = sda_pipe[Depth-1];

  assign scl_rise_o = scl_o & ~scl_prev;
  assign scl_fall_o = ~scl_o & scl_prev;
  assign start_o    = scl_o & scl_prev & sda_prev & ~sda_o;
  assign stop_o     = scl_o & scl_prev & ~sda_prev & sda_o;
endmodule

// File: rtl/i2c_tgt_addr_match.sv
module i2c_tgt_addr_match
  import i2c_tgt_pkg::*;
(
  input  logic [7:0] addr_byte_i,
  input  logic       cfg_alt_id_i,
  input  logic [1:0] cfg_ba_i,
  input  logic       cfg_ba2_pin_i,
  input  logic       a2_i,
  output logic       hit_o,
  output logic       is_cmd_o,
  output logic       is_rd_o
);
  logic [3:0] mem_type;
  logic [2:0] exp_ba;
  logic       ba_ok, type_mem, type_cmd;

  always_comb begin
    mem_type = cfg_alt_id_i ? TYPE_MEM_ALT : TYPE_MEM;
    exp_ba   = {cfg_ba2_pin_i ? a2_i : 1'b0, cfg_ba_i};
    ba_ok    = (addr_byte_i[3:1] == exp_ba);
    type_mem = (addr_byte_i[7:4] == mem_type);
    type_cmd = (addr_byte_i[7:4] == TYPE_CMD);
    hit_o    = ba_ok & (type_mem | type_cmd);
    is_cmd_o = type_cmd;
    is_rd_o  = addr_byte_i[0];
  end
endmodule

// File: rtl/i2c_dual_space_target.sv
module i2c_dual_space_target
  import i2c_tgt_pkg::*;
#(
  parameter int unsigned AddrW      = 8,
  parameter int unsigned PageBytes  = 16,
  parameter int unsigned SyncStages = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe_o,
  input  logic             cfg_alt_id_i,
  input  logic [1:0]       cfg_ba_i,
  input  logic             cfg_ba2_pin_i,
  input  logic             a2_i,
  output logic             reg_space_o,
  output logic [AddrW-1:0] reg_addr_o,
  output logic [7:0]       reg_wdata_o,
  output logic             reg_we_o,
  output logic             reg_re_o,
  input  logic [7:0]       reg_rdata_i,
  output logic             mon_halt_o,
  output logic             commit_o
);
  localparam int unsigned PageW = $clog2(PageBytes);
  localparam int unsigned CntW  = PageW + 1;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic hit, is_cmd, is_rd;

  tgt_state_e       state;
  logic [3:0]       bit_cnt;
  logic [7:0]       shreg, tx;
  logic [AddrW-1:0] ptr, ptr_wr_next;
  logic [CntW-1:0]  wcnt;
  logic             rd_q, cmd_q, rd_more, pend;

  i2c_tgt_sync #(.SyncStages(SyncStages)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  i2c_tgt_addr_match u_match (
    .addr_byte_i(shreg), .cfg_alt_id_i, .cfg_ba_i, .cfg_ba2_pin_i, .a2_i,
    .hit_o(hit), .is_cmd_o(is_cmd), .is_rd_o(is_rd)
  );

  // memory space stays inside its page; command space runs through all addresses
  always_comb begin
    if (cmd_q) ptr_wr_next = ptr + AddrW'(1);
    else       ptr_wr_next = {ptr[AddrW-1:PageW], ptr[PageW-1:0] + PageW'(1)};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state       <= ST_IDLE;
      bit_cnt     <= '0;
      shreg       <= '0;
      tx          <= '0;
      ptr         <= '0;
      wcnt        <= '0;
      rd_q        <= 1'b0;
      cmd_q       <= 1'b0;
      rd_more     <= 1'b0;
      pend        <= 1'b0;
      sda_oe_o    <= 1'b0;
      mon_halt_o  <= 1'b0;
      commit_o    <= 1'b0;
      reg_we_o    <= 1'b0;
      reg_re_o    <= 1'b0;
      reg_wdata_o <= '0;
    end else begin
      reg_we_o <= 1'b0;
      reg_re_o <= 1'b0;
      commit_o <= 1'b0;
      if (start_det) begin
        state    <= ST_ADDR;
        bit_cnt  <= '0;
        sda_oe_o <= 1'b0;
        pend     <= 1'b0;
      end else if (stop_det) begin
        state      <= ST_IDLE;
        sda_oe_o   <= 1'b0;
        mon_halt_o <= 1'b0;
        commit_o   <= pend;
        pend       <= 1'b0;
      end else if (scl_rise) begin
        case (state)
          ST_ADDR, ST_PTR, ST_WR: begin
            shreg   <= {shreg[6:0], sda_s};
            bit_cnt <= bit_cnt + 4'd1;
          end
          ST_RD: bit_cnt <= bit_cnt + 4'd1;
          ST_RD_ACK: begin
            rd_more <= ~sda_s;
            if (!sda_s) ptr <= ptr + AddrW'(1);
          end
          default: ;
        endcase
      end else if (scl_fall) begin
        case (state)
          ST_ADDR: if (bit_cnt == 4'd8) begin
            if (hit) begin
              sda_oe_o   <= 1'b1;
              mon_halt_o <= 1'b1;
              cmd_q      <= is_cmd;
              rd_q       <= is_rd;
              state      <= ST_ADDR_ACK;
            end else begin
              state <= ST_IDLE;
            end
          end
          ST_PTR: if (bit_cnt == 4'd8) begin
            sda_oe_o <= 1'b1;
            ptr      <= AddrW'(shreg);
            state    <= ST_PTR_ACK;
          end
          ST_WR: if (bit_cnt == 4'd8) begin
            if (cmd_q || wcnt < CntW'(PageBytes)) begin
              sda_oe_o    <= 1'b1;
              reg_we_o    <= 1'b1;
              reg_wdata_o <= shreg;
              wcnt        <= wcnt + CntW'(1);
              pend        <= ~cmd_q;
              state       <= ST_WR_ACK;
            end else begin
              state <= ST_IDLE;
            end
          end
          ST_ADDR_ACK, ST_PTR_ACK, ST_WR_ACK: begin
            sda_oe_o <= 1'b0;
            bit_cnt  <= '0;
            if (state == ST_ADDR_ACK && rd_q) begin
              reg_re_o <= 1'b1;
              tx       <= reg_rdata_i;
              sda_oe_o <= ~reg_rdata_i[7];
              state    <= ST_RD;
            end else if (state == ST_ADDR_ACK) begin
              wcnt  <= '0;
              state <= ST_PTR;
            end else begin
              if (state == ST_WR_ACK) ptr <= ptr_wr_next;
              state <= ST_WR;
            end
          end
          ST_RD: begin
            if (bit_cnt == 4'd8) begin
              sda_oe_o <= 1'b0;
              state    <= ST_RD_ACK;
            end else begin
              tx       <= {tx[6:0], 1'b0};
              sda_oe_o <= ~tx[6];
            end
          end
          ST_RD_ACK: begin
            bit_cnt <= '0;
            if (rd_more) begin
              reg_re_o <= 1'b1;
              tx       <= reg_rdata_i;
              sda_oe_o <= ~reg_rdata_i[7];
              state    <= ST_RD;
            end else begin
              state <= ST_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign reg_space_o = cmd_q;
  assign reg_addr_o  = ptr;

  assert_commit_one_cycle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> !commit_o);
  assert_commit_follows_stop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> $past(stop_det));
  assert_halt_cleared_by_stop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> !mon_halt_o);
  assert_write_inside_txn_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> mon_halt_o);
  assert_read_inside_txn_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_re_o |-> mon_halt_o);
  assert_idle_released_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_IDLE) |-> !sda_oe_o);
  assert_drive_change_scl_low_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_o != $past(sda_oe_o)) |-> (!$past(scl_s) || $past(start_det) || $past(stop_det)));
endmodule

// File: tb/i2c_dual_space_target_tb.sv
module i2c_dual_space_target_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_bus;
  logic sda_oe;
  logic cfg_alt = 1'b0;
  logic [1:0] cfg_ba = 2'b01;
  logic cfg_ba2_pin = 1'b0;
  logic a2 = 1'b1;
  logic space, we, re, halt, commit;
  logic [7:0] addr, wdata, rdata;

  logic [7:0] mem_arr [256];
  logic [7:0] cmd_arr [256];
  logic [7:0] exp_mem [256];
  logic [7:0] exp_cmd [256];

  int n_cmp = 0;
  int n_bad = 0;
  int commit_cnt = 0;
  int exp_commits = 0;
  int drive_viol = 0;
  int wide_commit = 0;
  logic prev_oe = 1'b0, prev_scl = 1'b1, prev_commit = 1'b0;

  always #10 clk = ~clk;

  assign sda_bus = sda_m & ~sda_oe;
  assign rdata   = space ? cmd_arr[addr] : mem_arr[addr];

  i2c_dual_space_target u_dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe_o(sda_oe),
    .cfg_alt_id_i(cfg_alt), .cfg_ba_i(cfg_ba), .cfg_ba2_pin_i(cfg_ba2_pin), .a2_i(a2),
    .reg_space_o(space), .reg_addr_o(addr), .reg_wdata_o(wdata), .reg_we_o(we),
    .reg_re_o(re), .reg_rdata_i(rdata), .mon_halt_o(halt), .commit_o(commit)
  );

  // register-bus target and per-clock bus monitors
  always @(posedge clk) begin
    if (we) begin
      if (space) cmd_arr[addr] <= wdata;
      else       mem_arr[addr] <= wdata;
    end
    if (commit) commit_cnt <= commit_cnt + 1;
    if (commit && prev_commit) wide_commit <= wide_commit + 1;
    if (rst_n && prev_oe != sda_oe && prev_scl && scl_m) drive_viol <= drive_viol + 1;
    prev_oe     <= sda_oe;
    prev_scl    <= scl_m;
    prev_commit <= commit;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wt(4); scl_m = 1'b1; wt(8); sda_m = 1'b0; wt(8); scl_m = 1'b0; wt(4);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(4); scl_m = 1'b1; wt(8); sda_m = 1'b1; wt(8);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wt(4); scl_m = 1'b1; wt(8); scl_m = 1'b0; wt(4);
    end
    sda_m = 1'b1; wt(4); scl_m = 1'b1; wt(4); ack = ~sda_bus; wt(4); scl_m = 1'b0; wt(4);
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wt(4); scl_m = 1'b1; wt(4); b[i] = sda_bus; wt(4); scl_m = 1'b0; wt(4);
    end
    sda_m = ~give_ack; wt(4); scl_m = 1'b1; wt(8); scl_m = 1'b0; wt(2); sda_m = 1'b1; wt(2);
  endtask

  task automatic mem_write(input logic [7:0] abyte, input logic [7:0] ptr,
                           input logic [7:0] d0, input int n, input string req);
    logic ack;
    bus_start();
    send_byte(abyte, ack); chk({req, " addr ack"}, ack, 1);
    send_byte(ptr, ack);   chk({req, " ptr ack"}, ack, 1);
    for (int k = 0; k < n; k++) begin
      send_byte(d0 + 8'(k), ack); chk({req, " data ack"}, ack, 1);
    end
    bus_stop(); wt(8);
  endtask

  task automatic addr_only(input logic [7:0] abyte, input logic exp_ack, input string req);
    logic ack;
    bus_start();
    send_byte(abyte, ack);
    chk({req, " address ack"}, ack, exp_ack);
    chk({req, " halt during txn"}, halt, exp_ack);
    bus_stop(); wt(8);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic ack;
    logic [7:0] b;
    int bad_cells;
    for (int i = 0; i < 256; i++) begin
      mem_arr[i] = 8'h00; cmd_arr[i] = 8'h00; exp_mem[i] = 8'h00; exp_cmd[i] = 8'h00;
    end
    wt(5);
    chk("R1 sda_oe", sda_oe, 0); chk("R1 halt", halt, 0);
    chk("R1 commit", commit, 0); chk("R1 we", we, 0); chk("R1 re", re, 0);
    rst_n = 1'b1; wt(10);

    // R6 / R8: simple memory page write closed by Stop
    mem_write(8'hA2, 8'h3C, 8'h11, 4, "R6");
    for (int k = 0; k < 4; k++) exp_mem[8'h3C + k] = 8'h11 + 8'(k * 17) - 8'(k * 16);
    exp_commits++;
    chk("R6 mem[3C]", mem_arr[8'h3C], 8'h11); chk("R6 mem[3F]", mem_arr[8'h3F], 8'h14);
    chk("R8 commit after page write", commit_cnt, exp_commits);
    chk("R5 halt after stop", halt, 0);

    // R7: wrap within page
    mem_write(8'hA2, 8'h5E, 8'hA1, 3, "R7");
    exp_mem[8'h5E] = 8'hA1; exp_mem[8'h5F] = 8'hA2; exp_mem[8'h50] = 8'hA3; exp_commits++;
    chk("R7 wrap mem[50]", mem_arr[8'h50], 8'hA3);
    chk("R7 no spill mem[60]", mem_arr[8'h60], 8'h00);

    // R7: 17th byte refused
    bus_start();
    send_byte(8'hA2, ack); send_byte(8'h70, ack);
    for (int k = 0; k < 17; k++) begin
      send_byte(8'h80 + 8'(k), ack);
      chk("R7 page byte ack", ack, (k < 16) ? 1 : 0);
      if (k < 16) exp_mem[8'h70 + k] = 8'h80 + 8'(k);
    end
    bus_stop(); wt(8); exp_commits++;
    chk("R7 mem[70] kept", mem_arr[8'h70], 8'h80);
    chk("R7 mem[7F]", mem_arr[8'h7F], 8'h8F);
    chk("R8 commit after full page", commit_cnt, exp_commits);

    // R10 / R3: command space write, full wrap, no commit
    mem_write(8'h92, 8'hFE, 8'hC1, 3, "R10");
    exp_cmd[8'hFE] = 8'hC1; exp_cmd[8'hFF] = 8'hC2; exp_cmd[8'h00] = 8'hC3;
    chk("R10 cmd[00]", cmd_arr[8'h00], 8'hC3);
    chk("R3 mem[FE] untouched", mem_arr[8'hFE], 8'h00);
    chk("R8 no commit for command space", commit_cnt, exp_commits);

    // R9 / R5: pointer write, repeated start, sequential read
    bus_start();
    send_byte(8'hA2, ack); send_byte(8'h3C, ack);
    bus_start();
    chk("R5 halt through repeated start", halt, 1);
    send_byte(8'hA3, ack); chk("R9 read addr ack", ack, 1);
    for (int k = 0; k < 4; k++) begin
      recv_byte(k < 3, b);
      chk("R9 read byte", b, exp_mem[8'h3C + k]);
    end
    chk("R9 sda released after nack", sda_oe, 0);
    bus_stop(); wt(8);
    chk("R8 no commit for pointer-only write", commit_cnt, exp_commits);

    // R3: command space read across 0xFF
    bus_start();
    send_byte(8'h92, ack); send_byte(8'hFF, ack);
    bus_start(); send_byte(8'h93, ack);
    recv_byte(1'b1, b); chk("R3 cmd read FF", b, exp_cmd[8'hFF]);
    recv_byte(1'b0, b); chk("R3 cmd read 00", b, exp_cmd[8'h00]);
    bus_stop(); wt(8);

    // R2: alternate memory type code
    addr_only(8'hB2, 1'b0, "R2 1011 unselected");
    cfg_alt = 1'b1;
    mem_write(8'hB2, 8'h20, 8'h5A, 1, "R2");
    exp_mem[8'h20] = 8'h5A; exp_commits++;
    chk("R2 alt write mem[20]", mem_arr[8'h20], 8'h5A);
    addr_only(8'hA2, 1'b0, "R2 1010 unselected");

    // R4: bus address bits
    cfg_ba2_pin = 1'b1; a2 = 1'b1;
    addr_only(8'hB2, 1'b0, "R4 bit2 mismatch");
    addr_only(8'hBA, 1'b1, "R4 bit2 from pin");
    a2 = 1'b0;
    addr_only(8'hB2, 1'b1, "R4 pin low");
    addr_only(8'hB4, 1'b0, "R4 bits1:0 mismatch");
    addr_only(8'h9A, 1'b0, "R4 cmd bit2 mismatch");

    // R8 / R9: data write ended by repeated start, pointer kept
    bus_start();
    send_byte(8'hB2, ack); send_byte(8'h40, ack); send_byte(8'h77, ack);
    exp_mem[8'h40] = 8'h77;
    bus_start(); send_byte(8'hB3, ack);
    recv_byte(1'b0, b); chk("R9 pointer kept after write", b, exp_mem[8'h41]);
    bus_stop(); wt(8);
    chk("R8 no commit after repeated start", commit_cnt, exp_commits);
    chk("R5 halt cleared", halt, 0);

    bad_cells = 0;
    for (int i = 0; i < 256; i++) begin
      if (mem_arr[i] !== exp_mem[i]) bad_cells++;
      if (cmd_arr[i] !== exp_cmd[i]) bad_cells++;
    end
    chk("R6 full array compare", bad_cells, 0);
    chk("R11 drive changed while SCL high", drive_viol, 0);
    chk("R8 commit wider than one cycle", wide_commit, 0);
    finish_run();
  end
endmodule